// File: doc/BRIEF.md
# PCI Configuration Access Translator

This block sits between a host register port and a PCI bus-cycle engine. The host programs a 32-bit configuration address register, then reads or writes a data port. Each data-port access becomes one bus request: a configuration read, a configuration write, or a special cycle. The block forms the AD-bus address from the register. When the bus number is zero it builds a Type 0 address, in which the device number selects one line of the upper address bits. For any other bus number it passes the address through in Type 1 form.

The host sees a single-request handshake. `host_req_i` is sampled only while the block is idle. `host_busy_o` stays high while the access is in progress. `host_ready_o` pulses for one cycle when the access completes, and `host_rdata_o` is valid in that cycle. A master abort reported by the bus engine is absorbed: writes complete as usual and reads return zero. No error is signalled.

Top module: `pci_cfg_xlat`

## Requirements
- R1: Reset clears the address register to 0. A write to the address register (`host_sel_i`=0) stores all 32 bits, and a later read of it returns them unchanged. Such accesses never raise `bus_req_o`, and `host_ready_o` pulses in the cycle after acceptance.
- R2: Type 0 address, used when register bits 23:16 are zero. With device number DN = bits 15:11 and DN below 16, AD[16+DN] is 1 and the rest of AD31:16 is 0. AD15:11 is 0, AD10:8 carries register bits 10:8, AD7:2 carries register bits 7:2, and AD1:0 is 00.
- R3: Type 0 with DN from 16 to 31 drives AD31:16 to all zero. No device is selected.
- R4: Type 1 address, used when register bits 23:16 are nonzero. AD31:24 is 0, AD23:2 is copied from the register, and AD1:0 is 01.
- R5: A data-port read with register bit 31 set issues `bus_cmd_o`=0 (configuration read). On normal completion the host receives `bus_rdata_i`.
- R6: A data-port write with bit 31 set, when the register is not 0x8000_FF00, issues `bus_cmd_o`=1 (configuration write) with `bus_wdata_o` equal to the host write data.
- R7: A data-port write while the register holds exactly 0x8000_FF00 issues `bus_cmd_o`=2 (special cycle) with `bus_addr_o`=0 and the host data on `bus_wdata_o`. A data-port read at that register value is an ordinary configuration read.
- R8: A data-port access with register bit 31 clear raises no bus request. It completes in the cycle after acceptance, and a read returns 0.
- R9: When `bus_abort_i` accompanies `bus_done_i`, a read returns 0 and a write completes with the same timing as a normal write.
- R10: `bus_req_o` rises in the cycle after acceptance and holds, with its command, address and data stable, until `bus_done_i` is sampled. In the next cycle `host_ready_o` is 1 for exactly one cycle and `bus_req_o` is 0. `host_busy_o` is 1 from acceptance until that ready cycle ends.
- R11: `host_req_i` asserted while `host_busy_o` is 1 is ignored: it changes neither the address register nor the bus request in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_req_i | input | 1 | Host access request, sampled while idle |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_sel_i | input | 1 | 0 = address register, 1 = data port |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Read data, valid with host_ready_o |
| host_ready_o | output | 1 | One-cycle completion pulse |
| host_busy_o | output | 1 | Access in progress |
| bus_req_o | output | 1 | Request to bus-cycle engine |
| bus_cmd_o | output | 2 | 0 cfg read, 1 cfg write, 2 special cycle |
| bus_addr_o | output | 32 | AD-bus address phase value |
| bus_wdata_o | output | 32 | Write data / special-cycle message |
| bus_done_i | input | 1 | Bus engine completion |
| bus_abort_i | input | 1 | Completion ended in master abort |
| bus_rdata_i | input | 32 | Read data from bus engine |

## Verification
The bench covers the boundaries of the device select. Device 0 and device 15 check the ends of the one-hot range, and device 20 must select nothing. A decoder that wrapped the index would select a stray line there, and one that dropped the range check would index past the upper bits. It checks that the special-cycle value applies only to writes and only at the exact register value. A design that compared too few bits, or that also converted reads, would issue the wrong command. It issues aborted reads with nonzero engine data, where a design that leaked the data would return garbage. It also sends requests while busy, which a design with a loose idle check would use to overwrite the address register in mid-transaction.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;
  typedef enum logic [1:0] {
    CMD_CFG_RD  = 2'd0,
    CMD_CFG_WR  = 2'd1,
    CMD_SPECIAL = 2'd2
  } bus_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_RESP = 2'd2
  } seq_st_e;

  localparam logic [31:0] SPECIAL_KEY = 32'h8000_FF00;
  localparam int unsigned AD_SEL_LINES = 16;
endpackage

// File: rtl/cfg_addr_gen.sv
module cfg_addr_gen
  import pci_cfg_pkg::*;
#(
  parameter int unsigned DEV_SEL_N = AD_SEL_LINES
) (
  input  logic [23:2] cfg_addr_i,
  output logic [31:0] ad_o,
  output logic        type1_o
);
  logic [7:0]              bus_num;
  logic [4:0]              dev_num;
  logic [AD_SEL_LINES-1:0] dev_sel;

  assign bus_num = cfg_addr_i[23:16];
  assign dev_num = cfg_addr_i[15:11];
  assign type1_o = (bus_num != 8'd0);

  // one select line per device; devices past DEV_SEL_N select nothing
  for (genvar g = 0; g < AD_SEL_LINES; g++) begin : g_sel
    if (g < DEV_SEL_N) begin : g_on
      assign dev_sel[g] = (dev_num == 5'(g));
    end else begin : g_off
      assign dev_sel[g] = 1'b0;
    end
  end

  always_comb begin
    if (type1_o) ad_o = {8'h00, cfg_addr_i[23:2], 2'b01};
    else         ad_o = {dev_sel, 5'b00000, cfg_addr_i[10:2], 2'b00};
  end
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
  import pci_cfg_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_req_i,
  input  logic              host_we_i,
  input  logic              host_sel_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  logic              cfg_en_i,
  input  logic              special_i,
  input  logic [DATA_W-1:0] addr_rdata_i,
  input  logic              bus_done_i,
  input  logic              bus_abort_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              addr_we_o,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              host_ready_o,
  output logic              host_busy_o,
  output logic              bus_req_o,
  output logic [1:0]        bus_cmd_o,
  output logic [DATA_W-1:0] bus_wdata_o
);
  seq_st_e           st_q;
  bus_cmd_e          cmd_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              accept, local_acc;

  assign accept    = host_req_i && (st_q == ST_IDLE);
  assign local_acc = !host_sel_i || !cfg_en_i;
  assign addr_we_o = accept && !host_sel_i && host_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cmd_q   <= CMD_CFG_RD;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          if (local_acc) begin
            rdata_q <= (!host_sel_i && !host_we_i) ? addr_rdata_i : '0;
            st_q    <= ST_RESP;
          end else begin
            cmd_q   <= !host_we_i ? CMD_CFG_RD : (special_i ? CMD_SPECIAL : CMD_CFG_WR);
            wdata_q <= host_wdata_i;
            st_q    <= ST_BUS;
          end
        end
        ST_BUS: if (bus_done_i) begin
          // master abort is absorbed: reads see zero
          rdata_q <= (cmd_q == CMD_CFG_RD && !bus_abort_i) ? bus_rdata_i : '0;
          st_q    <= ST_RESP;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_req_o    = (st_q == ST_BUS);
  assign host_ready_o = (st_q == ST_RESP);
  assign host_busy_o  = (st_q != ST_IDLE);
  assign bus_cmd_o    = cmd_q;
  assign bus_wdata_o  = wdata_q;
  assign host_rdata_o = rdata_q;

  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_done_i) |=> (bus_req_o && $stable(bus_cmd_o) && $stable(bus_wdata_o)));
  // R10
  done_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_done_i) |=> (host_ready_o && !bus_req_o));
  // R10
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_ready_o |=> !host_ready_o);
  // R9
  abort_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_done_i && bus_abort_i && bus_cmd_o == 2'd0) |=> (host_rdata_o == '0));
endmodule

// File: rtl/pci_cfg_xlat.sv
module pci_cfg_xlat
  import pci_cfg_pkg::*;
#(
  parameter int unsigned DEV_SEL_N = AD_SEL_LINES
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        host_req_i,
  input  logic        host_we_i,
  input  logic        host_sel_i,
  input  logic [31:0] host_wdata_i,
  output logic [31:0] host_rdata_o,
  output logic        host_ready_o,
  output logic        host_busy_o,
  output logic        bus_req_o,
  output logic [1:0]  bus_cmd_o,
  output logic [31:0] bus_addr_o,
  output logic [31:0] bus_wdata_o,
  input  logic        bus_done_i,
  input  logic        bus_abort_i,
  input  logic [31:0] bus_rdata_i
);
  logic [31:0] addr_q, ad;
  logic        addr_we, type1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (addr_we) addr_q <= host_wdata_i;
  end

  cfg_addr_gen #(.DEV_SEL_N(DEV_SEL_N)) u_addr_gen (
    .cfg_addr_i (addr_q[23:2]),
    .ad_o       (ad),
    .type1_o    (type1)
  );

  cfg_seq #(.DATA_W(32)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_req_i   (host_req_i),
    .host_we_i    (host_we_i),
    .host_sel_i   (host_sel_i),
    .host_wdata_i (host_wdata_i),
    .cfg_en_i     (addr_q[31]),
    .special_i    (addr_q == SPECIAL_KEY),
    .addr_rdata_i (addr_q),
    .bus_done_i   (bus_done_i),
    .bus_abort_i  (bus_abort_i),
    .bus_rdata_i  (bus_rdata_i),
    .addr_we_o    (addr_we),
    .host_rdata_o (host_rdata_o),
    .host_ready_o (host_ready_o),
    .host_busy_o  (host_busy_o),
    .bus_req_o    (bus_req_o),
    .bus_cmd_o    (bus_cmd_o),
    .bus_wdata_o  (bus_wdata_o)
  );

  assign bus_addr_o = (bus_cmd_o == 2'd2) ? '0 : ad;

  // R2
  type0_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !type1 && bus_cmd_o != 2'd2) |-> ($onehot0(bus_addr_o[31:16]) && bus_addr_o[15:11] == 5'd0 && bus_addr_o[1:0] == 2'b00));
  // R8
  disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_req_i && !host_busy_o && host_sel_i && !addr_q[31]) |=> !bus_req_o);
  // R11
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_busy_o && !host_ready_o) |=> $stable(addr_q));
endmodule

// File: tb/pci_cfg_xlat_tb.sv
module pci_cfg_xlat_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] KEY = 32'h8000_FF00;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 0, we = 0, sel = 0, done = 0, abort = 0;
  logic [31:0] wdata = 0, brdata = 0;
  logic [31:0] rdata, baddr, bwdata;
  logic        ready, busy, breq;
  logic [1:0]  bcmd;
  int checks = 0, failures = 0;
  bit finished = 0;
  logic [31:0] m_addr = 0;  // reference copy of address register

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_cfg_xlat dut_i (
    .clk_i(clk), .rst_ni(rst_n), .host_req_i(req), .host_we_i(we), .host_sel_i(sel),
    .host_wdata_i(wdata), .host_rdata_o(rdata), .host_ready_o(ready), .host_busy_o(busy),
    .bus_req_o(breq), .bus_cmd_o(bcmd), .bus_addr_o(baddr), .bus_wdata_o(bwdata),
    .bus_done_i(done), .bus_abort_i(abort), .bus_rdata_i(brdata)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_ad(input logic [31:0] a);
    logic [31:0] r;
    int dn;
    r = '0;
    if (a[23:16] == 8'd0) begin
      dn = int'(a[15:11]);
      if (dn < 16) r[16+dn] = 1'b1;
      r[10:2] = a[10:2];
    end else begin
      r[23:2] = a[23:2];
      r[1:0]  = 2'b01;
    end
    return r;
  endfunction

  // address register or disabled data-port access: no bus cycle
  task automatic local_acc(input string rq, input logic w, input logic s, input logic [31:0] d);
    logic [31:0] exp_rd;
    exp_rd = (!s && !w) ? m_addr : 32'h0;
    @(negedge clk); req = 1; we = w; sel = s; wdata = d;
    @(negedge clk); req = 0;
    if (!s && w) m_addr = d;
    chk(rq, {31'd0, ready}, 32'd1);
    chk(rq, {31'd0, breq}, 32'd0);
    chk(rq, rdata, exp_rd);
    @(negedge clk);
    chk(rq, {30'd0, ready, busy}, 32'd0);
  endtask

  task automatic bus_acc(input string rq, input logic w, input logic [31:0] d, input int dly,
                         input logic ab, input logic [31:0] eng_rd, input bit inject);
    logic [1:0]  exp_cmd;
    logic [31:0] exp_addr, exp_rd;
    exp_cmd  = !w ? 2'd0 : (m_addr == KEY ? 2'd2 : 2'd1);
    exp_addr = (exp_cmd == 2'd2) ? 32'h0 : ref_ad(m_addr);
    exp_rd   = (!w && !ab) ? eng_rd : 32'h0;
    @(negedge clk); req = 1; we = w; sel = 1; wdata = d;
    @(negedge clk); req = 0;
    chk({rq, " R10 req"}, {30'd0, breq, busy}, 32'd3);
    chk({rq, " cmd"}, {30'd0, bcmd}, {30'd0, exp_cmd});
    chk({rq, " addr"}, baddr, exp_addr);
    if (w) chk({rq, " wdata"}, bwdata, d);
    for (int i = 0; i < dly; i++) begin
      if (inject && i == 0) begin req = 1; we = 1; sel = 0; wdata = 32'h1234_5678; end
      @(negedge clk); req = 0;
      chk({rq, " R10 hold"}, {29'd0, breq, ready, bcmd == exp_cmd}, 32'h5);
      chk({rq, " R10 addr stable"}, baddr, exp_addr);
    end
    done = 1; abort = ab; brdata = eng_rd;
    @(negedge clk); done = 0; abort = 0; brdata = 32'hFFFF_FFFF;
    chk({rq, " R10 ready"}, {30'd0, ready, breq}, 32'd2);
    chk({rq, " rdata"}, rdata, exp_rd);
    @(negedge clk);
    chk({rq, " R10 idle"}, {30'd0, ready, busy}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", {29'd0, ready, busy, breq}, 32'd0);
    rst_n = 1;
    local_acc("R1 reset read", 0, 0, 0);
    local_acc("R1 write", 1, 0, 32'hA5C3_5A3C);
    local_acc("R1 readback", 0, 0, 0);
    // Type 0, device 3, function 5, register 0x11
    local_acc("R2 set", 1, 0, 32'h8000_0000 | (3 << 11) | (5 << 8) | (8'h11 << 2));
    bus_acc("R2 R5 read dev3", 0, 0, 2, 0, 32'hDEAD_BEEF, 0);
    local_acc("R2 set", 1, 0, 32'h8000_0000 | (0 << 11) | (7 << 8) | (8'h3F << 2));
    bus_acc("R2 R5 read dev0", 0, 0, 0, 0, 32'h0BAD_F00D, 0);
    local_acc("R2 set", 1, 0, 32'h8000_0000 | (15 << 11) | (1 << 8) | (8'h04 << 2));
    bus_acc("R2 R6 write dev15", 1, 32'hCAFE_0001, 0, 0, 0, 0);
    local_acc("R3 set", 1, 0, 32'h8000_0000 | (20 << 11) | (2 << 8));
    bus_acc("R3 read dev20", 0, 0, 1, 0, 32'h1111_2222, 0);
    local_acc("R4 set", 1, 0, 32'h8007_A9FC);
    bus_acc("R4 R6 type1 write", 1, 32'h5555_AAAA, 3, 0, 0, 0);
    local_acc("R7 set", 1, 0, KEY);
    bus_acc("R7 special", 1, 32'h0000_BEEF, 1, 0, 0, 0);
    bus_acc("R7 read at key", 0, 0, 1, 0, 32'h7777_0000, 0);
    local_acc("R7 near key", 1, 0, KEY | 32'h4);
    bus_acc("R7 write near key", 1, 32'h0000_0042, 0, 0, 0, 0);
    local_acc("R8 set", 1, 0, 32'h0000_1900);
    local_acc("R8 disabled read", 0, 1, 0);
    local_acc("R8 disabled write", 1, 1, 32'h9999_9999);
    local_acc("R9 set", 1, 0, 32'h8000_2800);
    bus_acc("R9 abort read", 0, 0, 2, 1, 32'hABCD_EF01, 0);
    bus_acc("R9 abort write", 1, 32'h0F0F_0F0F, 1, 1, 0, 0);
    bus_acc("R11 busy req", 0, 0, 3, 0, 32'h2468_ACE0, 1);
    local_acc("R11 addr kept", 0, 0, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule